// File: doc/BRIEF.md
# Dual-Host Register Access Arbiter

This block places a shared byte-wide register file behind two independent host ports, called host A and host B. Host A is the side that fills the mailbox, and host B is the side that drains it. The serial front ends that feed the ports are outside this block. Both hosts may issue reads and writes in the same cycle. Arbitration is combinational on the incoming requests, and each port gets a registered response one cycle later. The response carries an acknowledge, a valid flag and the read data.

Addresses 0x20 to 0x25 form a mailbox window. Host A writes the mailbox and host B reads it. Access inside the window never counts as a conflict. When both hosts address locations outside the window in the same cycle, a sticky collision flag is set. The host without priority then gets an invalid response, and its write is discarded. The `prio_b` input selects which host wins. The flag is bit 0 of a read-only status byte at address 0x3F. It clears when either host reads that byte with a valid response.

Top module: `dual_host_reg_arbiter`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, the collision flag is 0, and neither port acknowledges.
- R2: A valid write stores its byte at the 6-bit address. A read returns the stored byte with ack=1 and ok=1 in the cycle after the request.
- R3: When one host addresses the mailbox window (0x20..0x25) and the other addresses a location outside it, both transfers complete with ok=1 and no collision is raised.
- R4: Host A writes to the mailbox are readable by host B. A host B read of a mailbox byte that host A writes in the same cycle returns the previous content. Two concurrent accesses that are both inside the window do not raise a collision.
- R5: A host B write to a mailbox address is acknowledged but leaves the mailbox content unchanged.
- R6: When both hosts request addresses outside the window in the same cycle, the collision output reads 1 after that clock edge.
- R7: On a collision, the losing host gets ack=1 and ok=0, and its write has no effect. The winning host completes normally.
- R8: With prio_b=0 host A wins a collision. With prio_b=1 host B wins.
- R9: The collision flag stays set until a valid read of status address 0x3F, which returns the flag in bit 0 and clears it. Writes to 0x3F have no effect.
- R10: If a collision occurs in the same cycle as a status read that would clear the flag, the flag stays set.
- R11: Each port raises ack exactly in the cycle after a request, and never without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both hosts |
| rst | input | 1 | Synchronous active-high reset |
| prio_b | input | 1 | 0: host A wins collisions; 1: host B wins |
| a_req | input | 1 | Host A request strobe |
| a_wr | input | 1 | Host A write (1) or read (0) |
| a_addr | input | 6 | Host A register address |
| a_wdata | input | 8 | Host A write data |
| a_ack | output | 1 | Host A response strobe |
| a_ok | output | 1 | Host A transfer valid |
| a_rdata | output | 8 | Host A read data |
| b_req | input | 1 | Host B request strobe |
| b_wr | input | 1 | Host B write (1) or read (0) |
| b_addr | input | 6 | Host B register address |
| b_wdata | input | 8 | Host B write data |
| b_ack | output | 1 | Host B response strobe |
| b_ok | output | 1 | Host B transfer valid |
| b_rdata | output | 8 | Host B read data |
| collision | output | 1 | Sticky collision flag |

## Verification
The bench targets the window edges 0x25 and 0x26 together with 0x1F. A design with an off-by-one window bound would raise a false collision at the edge, or miss a real one. It pits writes to the same register against each other under both priority settings. A design that ignored `prio_b`, or let the loser's write through, would leave the wrong byte behind. It reads a mailbox byte in the very cycle it is rewritten, and it reads the status byte in a cycle that also collides. A design that forwarded write data, or let the clear beat the set, would return the new byte early or drop the flag. It also sends host B writes into the mailbox, which a design that failed to block them would let corrupt the data.

// File: rtl/dhra_pkg.sv
package dhra_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NPORT  = 2;

    localparam logic [ADDR_W-1:0] MBX_LO    = ADDR_W'(8'h20);
    localparam logic [ADDR_W-1:0] MBX_HI    = ADDR_W'(8'h25);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(8'h3F);

    typedef enum logic {
        PRIO_A = 1'b0,
        PRIO_B = 1'b1
    } prio_e;

    typedef struct packed {
        logic              req;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic              ack;
        logic              ok;
        logic [DATA_W-1:0] rdata;
    } host_rsp_t;

    function automatic logic in_mbx(input logic [ADDR_W-1:0] addr);
        return (addr >= MBX_LO) && (addr <= MBX_HI);
    endfunction

endpackage

// File: rtl/dhra_arbiter.sv
module dhra_arbiter
    import dhra_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  prio_e                  prio,
    input  host_req_t [NPORT-1:0]  hreq,
    output logic      [NPORT-1:0]  ok,
    output logic      [NPORT-1:0]  we,
    output logic                   coll_q
);
    logic both_out;
    logic clr;
    logic [NPORT-1:0] loses;
    logic [NPORT-1:0] stat_rd;

    assign both_out = hreq[0].req && hreq[1].req &&
                      !in_mbx(hreq[0].addr) && !in_mbx(hreq[1].addr);

    assign loses[0] = both_out && (prio == PRIO_B);
    assign loses[1] = both_out && (prio == PRIO_A);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign ok[p]      = hreq[p].req && !loses[p];
        assign stat_rd[p] = ok[p] && !hreq[p].wr && (hreq[p].addr == STAT_ADDR);
    end

    // host A may write anywhere but status; host B may not write the mailbox
    assign we[0] = ok[0] && hreq[0].wr && (hreq[0].addr != STAT_ADDR);
    assign we[1] = ok[1] && hreq[1].wr && (hreq[1].addr != STAT_ADDR) &&
                   !in_mbx(hreq[1].addr);

    assign clr = |stat_rd;

    always_ff @(posedge clk) begin
        if (rst)           coll_q <= 1'b0;
        else if (both_out) coll_q <= 1'b1;
        else if (clr)      coll_q <= 1'b0;
    end

    // R6
    coll_set_chk: assert property (@(posedge clk) disable iff (rst)
        both_out |=> coll_q);

    // R10
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (both_out && clr) |=> coll_q);

endmodule

// File: rtl/dhra_regfile.sv
module dhra_regfile
    import dhra_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0]              we,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
    input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
    output logic [NPORT-1:0][DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we[0] && addr[0] == ADDR_W'(i))
                mem[i] <= wdata[0];
            else if (we[1] && addr[1] == ADDR_W'(i))
                mem[i] <= wdata[1];
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rdata[p] = mem[addr[p]];
    end

    // R7
    dual_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(we[0] && we[1] && addr[0] == addr[1]));

endmodule

// File: rtl/dhra_rsp_reg.sv
module dhra_rsp_reg
    import dhra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              ok,
    input  logic [DATA_W-1:0] rd,
    output host_rsp_t         rsp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.ack   <= req;
            rsp.ok    <= req && ok;
            rsp.rdata <= req ? rd : '0;
        end
    end

    // R7
    ok_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        rsp.ok |-> rsp.ack);

endmodule

// File: rtl/dual_host_reg_arbiter.sv
module dual_host_reg_arbiter
    import dhra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prio_b,
    input  logic              a_req,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic              a_ack,
    output logic              a_ok,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_req,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic              b_ack,
    output logic              b_ok,
    output logic [DATA_W-1:0] b_rdata,
    output logic              collision
);
    host_req_t [NPORT-1:0]             hreq;
    host_rsp_t [NPORT-1:0]             hrsp;
    logic      [NPORT-1:0]             ok;
    logic      [NPORT-1:0]             we;
    logic      [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic      [NPORT-1:0][DATA_W-1:0] wdata_v;
    logic      [NPORT-1:0][DATA_W-1:0] mem_rd;
    logic      [NPORT-1:0][DATA_W-1:0] rd_mux;
    logic                              coll_q;
    prio_e                             prio;

    assign hreq[0] = {a_req, a_wr, a_addr, a_wdata};
    assign hreq[1] = {b_req, b_wr, b_addr, b_wdata};
    assign prio    = prio_e'(prio_b);

    dhra_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .prio   (prio),
        .hreq   (hreq),
        .ok     (ok),
        .we     (we),
        .coll_q (coll_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign addr_v[p]  = hreq[p].addr;
        assign wdata_v[p] = hreq[p].wdata;
        assign rd_mux[p]  = (hreq[p].addr == STAT_ADDR) ? DATA_W'(coll_q) : mem_rd[p];

        dhra_rsp_reg u_rsp (
            .clk (clk),
            .rst (rst),
            .req (hreq[p].req),
            .ok  (ok[p]),
            .rd  (rd_mux[p]),
            .rsp (hrsp[p])
        );
    end

    dhra_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .addr  (addr_v),
        .wdata (wdata_v),
        .rdata (mem_rd)
    );

    assign a_ack     = hrsp[0].ack;
    assign a_ok      = hrsp[0].ok;
    assign a_rdata   = hrsp[0].rdata;
    assign b_ack     = hrsp[1].ack;
    assign b_ok      = hrsp[1].ok;
    assign b_rdata   = hrsp[1].rdata;
    assign collision = coll_q;

    // R11
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        a_req |=> a_ack);

    // R11
    no_stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !b_req |=> !b_ack);

    // R8
    prio_a_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (a_req && b_req && !in_mbx(a_addr) && !in_mbx(b_addr) && !prio_b)
            |=> (a_ok && !b_ok));

    // R3
    mbx_no_coll_chk: assert property (@(posedge clk) disable iff (rst)
        (a_req && b_req && (in_mbx(a_addr) || in_mbx(b_addr)) && !collision)
            |=> (!collision && a_ok && b_ok));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(collision) |-> $past((a_req && !a_wr && a_addr == STAT_ADDR) ||
                                   (b_req && !b_wr && b_addr == STAT_ADDR)));

endmodule

// File: tb/dual_host_reg_arbiter_tb.sv
module dual_host_reg_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prio_b = 1'b0;
    logic       a_req = 1'b0, a_wr = 1'b0, b_req = 1'b0, b_wr = 1'b0;
    logic [5:0] a_addr = '0, b_addr = '0;
    logic [7:0] a_wdata = '0, b_wdata = '0;
    logic       a_ack, a_ok, b_ack, b_ok, collision;
    logic [7:0] a_rdata, b_rdata;

    int checks = 0;
    int errors = 0;
    int pos_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_host_reg_arbiter u_dut (
        .clk(clk), .rst(rst), .prio_b(prio_b),
        .a_req(a_req), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_ack(a_ack), .a_ok(a_ok), .a_rdata(a_rdata),
        .b_req(b_req), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_ack(b_ack), .b_ok(b_ok), .b_rdata(b_rdata),
        .collision(collision)
    );

    typedef struct {
        int         due;
        logic       aa, ao, achk;
        logic [7:0] ad;
        logic       ba, bo, bchk;
        logic [7:0] bd;
        logic       col;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] mem_m [64];
    logic       coll_m = 1'b0;

    function automatic logic win(input logic [5:0] a);
        return (a >= 6'h20) && (a <= 6'h25);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expectations once the response register has loaded
    always @(posedge clk) begin
        pos_cnt++;
        #2;
        while (sb.size() > 0 && sb[0].due == pos_cnt) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "a_ack", int'(a_ack), int'(e.aa));
            chk(e.tag, "a_ok",  int'(a_ok),  int'(e.ao));
            if (e.achk) chk(e.tag, "a_rdata", int'(a_rdata), int'(e.ad));
            chk(e.tag, "b_ack", int'(b_ack), int'(e.ba));
            chk(e.tag, "b_ok",  int'(b_ok),  int'(e.bo));
            if (e.bchk) chk(e.tag, "b_rdata", int'(b_rdata), int'(e.bd));
            chk(e.tag, "collision", int'(collision), int'(e.col));
        end
    end

    // driver: one cycle of stimulus plus its expected outcome
    task automatic step(input string tag,
                        input logic ar, input logic aw, input logic [5:0] aad, input logic [7:0] awd,
                        input logic br, input logic bw, input logic [5:0] bad, input logic [7:0] bwd);
        exp_t e;
        logic both, aok, bok, clr;
        both = ar && br && !win(aad) && !win(bad);
        aok  = ar && !(both && prio_b);
        bok  = br && !(both && !prio_b);
        e.due  = pos_cnt + 1;
        e.tag  = tag;
        e.aa   = ar;
        e.ao   = aok;
        e.achk = aok && !aw;
        e.ad   = (aad == 6'h3F) ? {7'b0, coll_m} : mem_m[aad];
        e.ba   = br;
        e.bo   = bok;
        e.bchk = bok && !bw;
        e.bd   = (bad == 6'h3F) ? {7'b0, coll_m} : mem_m[bad];
        clr = (aok && !aw && aad == 6'h3F) || (bok && !bw && bad == 6'h3F);
        if (aok && aw && aad != 6'h3F) mem_m[aad] = awd;
        if (bok && bw && bad != 6'h3F && !win(bad)) mem_m[bad] = bwd;
        if (both) coll_m = 1'b1;
        else if (clr) coll_m = 1'b0;
        e.col = coll_m;
        sb.push_back(e);
        a_req = ar; a_wr = aw; a_addr = aad; a_wdata = awd;
        b_req = br; b_wr = bw; b_addr = bad; b_wdata = bwd;
        @(negedge clk);
        a_req = 1'b0; b_req = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "a_ack", int'(a_ack), 0);
        chk("R1", "b_ack", int'(b_ack), 0);
        chk("R1", "collision", int'(collision), 0);
        step("R1", 1, 0, 6'h07, 0, 1, 0, 6'h22, 0);
        step("R1", 1, 0, 6'h3F, 0, 0, 0, 0, 0);

        // R2: single-host write then read
        step("R2", 1, 1, 6'h05, 8'h3C, 0, 0, 0, 0);
        step("R2", 1, 0, 6'h05, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 1, 1, 6'h10, 8'hA5);
        step("R2", 0, 0, 0, 0, 1, 0, 6'h10, 0);
        step("R11", 0, 0, 0, 0, 0, 0, 0, 0);

        // R3: one in window, one outside
        step("R3", 1, 1, 6'h21, 8'h5A, 1, 1, 6'h11, 8'hC3);
        step("R3", 1, 0, 6'h11, 0, 1, 0, 6'h21, 0);
        step("R3", 1, 0, 6'h1F, 0, 1, 0, 6'h25, 0);

        // R4: mailbox transfer A -> B
        for (int i = 0; i < 6; i++)
            step("R4", 1, 1, 6'(6'h20 + i), 8'(8'h90 + i), 0, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            step("R4", 0, 0, 0, 0, 1, 0, 6'(6'h20 + i), 0);
        step("R4", 1, 1, 6'h22, 8'hE7, 1, 0, 6'h22, 0);
        step("R4", 0, 0, 0, 0, 1, 0, 6'h22, 0);
        step("R4", 1, 0, 6'h23, 0, 1, 0, 6'h23, 0);

        // R5: host B cannot write the mailbox
        step("R5", 0, 0, 0, 0, 1, 1, 6'h24, 8'hFF);
        step("R5", 1, 0, 6'h24, 0, 1, 0, 6'h24, 0);

        // R6 R7 R8: collisions under host A priority
        prio_b = 1'b0;
        step("R7", 1, 1, 6'h08, 8'h11, 1, 1, 6'h08, 8'h22);
        step("R7", 1, 0, 6'h08, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 1, 0, 6'h3F, 0);
        step("R9", 1, 0, 6'h3F, 0, 0, 0, 0, 0);
        step("R6", 1, 0, 6'h26, 0, 1, 0, 6'h1F, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9", 1, 0, 6'h3F, 0, 0, 0, 0, 0);

        // R8: host B priority
        prio_b = 1'b1;
        step("R8", 1, 1, 6'h30, 8'h77, 1, 1, 6'h31, 8'h66);
        step("R8", 1, 0, 6'h30, 0, 0, 0, 0, 0);
        step("R8", 1, 0, 6'h31, 0, 0, 0, 0, 0);
        step("R8", 1, 1, 6'h0C, 8'h44, 1, 1, 6'h0C, 8'h55);
        step("R8", 0, 0, 0, 0, 1, 0, 6'h0C, 0);

        // R10: clearing read collides in the same cycle
        step("R10", 1, 0, 6'h3F, 0, 1, 0, 6'h3F, 0);
        step("R10", 1, 0, 6'h02, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 1, 0, 6'h3F, 0);
        step("R10", 0, 0, 0, 0, 1, 0, 6'h3F, 0);

        // R9: status byte is read-only
        prio_b = 1'b0;
        step("R9", 1, 1, 6'h3F, 8'hFF, 0, 0, 0, 0);
        step("R9", 1, 0, 6'h3F, 0, 0, 0, 0, 0);
        step("R11", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R11", 0, 0, 0, 0, 1, 0, 6'h01, 0);

        repeat (3) @(negedge clk);
        chk("R11", "drained", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule